// File: doc/BRIEF.md
# Video Line Prefetch Sequencer

This block paces burst reads from an external frame store so that a 640x480, 8-bit-per-pixel raster always has its next scanline sitting in the line buffer before it is shown. It watches the vertical and horizontal sync outputs of a display timing generator, running from a 25 MHz pixel clock, and turns them into row-indexed read requests for a burst memory controller. Each request asks for one full line of 640 one-byte pixels.

A frame is armed only after vertical sync has been seen high and then falls. At that point the row counter returns to zero. The first horizontal sync rising edge of the frame preloads row 0, flagged as the preload. Each later rising edge requests the next row. After the last row the counter wraps to zero, and the block goes back to looking for the next vertical sync pulse. A request is never issued while the memory controller reports busy. A line event that lands during a busy or still-pending fetch raises a sticky overrun flag.

Top module: `line_prefetch_seq`

## Requirements
- R1: After reset, and after each completed frame, no request is issued and the row counter stays still until vsync_in has been seen high and then sampled low. in_frame goes to 1 in the cycle after the clock edge that first samples vsync_in low.
- R2: At frame start (the vsync_in falling edge that arms a frame), cur_row becomes 0 and overrun is cleared.
- R3: The first hsync_in rising edge of a frame requests row 0 with req_first = 1. req_valid is a single-cycle pulse, high in the cycle after the edge that samples hsync_in high.
- R4: Each later hsync_in rising edge in the frame requests the row shown on cur_row, with req_first = 0, and then cur_row increments by one. An hsync_in held high for several cycles counts as one event.
- R5: After the request for row ROWS-1, cur_row reads 0 and in_frame reads 0. Further hsync_in edges are ignored until the R1 arming sequence repeats.
- R6: With each request, req_addr equals req_row multiplied by 2^STRIDE_LOG2, and req_len equals LINE_PIXELS*BPP/8 bytes (640 by default).
- R7: A line event that arrives while mem_busy is 1 sets overrun. The request is held and then issued in the cycle after the first clock edge that samples mem_busy low. No request ever follows an edge that sampled mem_busy high.
- R8: A line event that arrives while a held request is still waiting sets overrun and adds no extra request. The row sequence is unchanged.
- R9: overrun stays 1 once set, including across the end of a frame, until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_in | input | 1 | Vertical sync from the timing generator, active high |
| hsync_in | input | 1 | Horizontal sync from the timing generator, active high |
| mem_busy | input | 1 | Burst memory controller is busy with a transfer |
| req_valid | output | 1 | One-cycle read request pulse |
| req_first | output | 1 | The current request is the preload of the frame's first line |
| req_row | output | ROW_W | Row index of the request |
| req_addr | output | ROW_W+STRIDE_LOG2 | Byte address of the row in the frame store |
| req_len | output | LEN_W | Burst length in bytes |
| cur_row | output | ROW_W | Row the next line event will fetch |
| overrun | output | 1 | Sticky flag: a line event met a busy or pending fetch |
| in_frame | output | 1 | A frame is armed and line events are being served |

## Verification
The bench builds the block with ROWS = 6, keeping STRIDE_LOG2 = 10 and the 640-pixel, 8-bit line. The short frame makes the wrap from the last row back to zero, the return to waiting for vertical sync and a second full frame reachable within a short run. The unchanged stride and line length keep the address and length values those of the full-size raster. The same short frame also leaves room to hold mem_busy across one line event and across two line events. This covers the deferred request, the dropped event and the overrun flag staying set across the frame boundary until it clears at the next frame start.

// File: rtl/lps_pkg.sv
// Shared types for the line prefetch sequencer.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package lps_pkg;

    // Frame-level phase of the sequencer.
    typedef enum logic [1:0] {
        PH_SEEK_HIGH = 2'd0,   // waiting to see vertical sync asserted
        PH_SEEK_LOW  = 2'd1,   // vertical sync seen high, waiting for its end
        PH_LINES     = 2'd2    // frame armed, serving line events
    } lps_phase_e;

endpackage

// File: rtl/lps_edge.sv
// Edge detector for a vector of synchronous level signals.
// Produces one-cycle rise/fall strobes combinationally from the current
// input and a registered copy; assumes inputs are already in the clk domain.
module lps_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Remember last sampled level of this bit.
        always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= 1'b0;
            else        prev[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev[i];
        assign fall[i] = ~sig[i] & prev[i];
    end

endmodule

// File: rtl/lps_frame_fsm.sv
// Frame phase controller: arms a frame when vertical sync has been seen
// high and then falls, and disarms after the last row has been requested.
// Assumes vs_fall is a one-cycle strobe from lps_edge.
module lps_frame_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vs_level,
    input  logic       vs_fall,
    input  logic       last_issue,
    output lps_phase_e phase,
    output logic       frame_start
);

    lps_phase_e phase_nx;

    // Next-phase decision.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_SEEK_HIGH: if (vs_level)   phase_nx = PH_SEEK_LOW;
            PH_SEEK_LOW:  if (vs_fall)    phase_nx = PH_LINES;
            PH_LINES:     if (last_issue) phase_nx = PH_SEEK_HIGH;
            default:                      phase_nx = PH_SEEK_HIGH;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_SEEK_HIGH;
        else        phase <= phase_nx;
    end

    assign frame_start = (phase == PH_SEEK_LOW) && vs_fall;

endmodule

// File: rtl/lps_line_issuer.sv
// Line request issuer: turns line events into row-indexed read requests,
// holds one request while the memory controller is busy, flags overruns
// and wraps the row counter after ROWS requests.
// Assumes line events are one-cycle strobes and frame_start is a strobe.
module lps_line_issuer #(
    parameter int ROWS  = 480,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             in_lines,
    input  logic             line_evt,
    input  logic             mem_busy,
    output logic             req_valid,
    output logic             req_first,
    output logic [ROW_W-1:0] req_row,
    output logic [ROW_W-1:0] next_row,
    output logic             overrun,
    output logic             last_issue
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic pending;
    logic want;
    logic fire;

    // Issue decision for this cycle.
    always_comb begin
        want       = in_lines && (line_evt || pending);
        fire       = want && !mem_busy;
        last_issue = fire && (next_row == LAST_ROW);
    end

    // Request, row counter, pending and overrun registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_first <= 1'b0;
            req_row   <= '0;
            next_row  <= '0;
            pending   <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            if (frame_start) begin
                next_row <= '0;
                pending  <= 1'b0;
                overrun  <= 1'b0;
            end else if (in_lines) begin
                if (line_evt && (pending || mem_busy)) overrun <= 1'b1;
                if (fire) begin
                    req_valid <= 1'b1;
                    req_first <= (next_row == '0);
                    req_row   <= next_row;
                    pending   <= 1'b0;
                    next_row  <= last_issue ? '0 : next_row + 1'b1;
                end else if (line_evt) begin
                    pending <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/line_prefetch_seq.sv
// Video line prefetch sequencer top: edge-detects the sync inputs, tracks
// the frame phase and issues one burst read per display line.
// Assumes sync inputs and mem_busy are synchronous to clk.
module line_prefetch_seq #(
    parameter int ROWS        = 480,
    parameter int LINE_PIXELS = 640,
    parameter int BPP         = 8,
    parameter int STRIDE_LOG2 = 10,
    localparam int ROW_W      = $clog2(ROWS),
    localparam int ADDR_W     = ROW_W + STRIDE_LOG2,
    localparam int LINE_BYTES = LINE_PIXELS * BPP / 8,
    localparam int LEN_W      = $clog2(LINE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              hsync_in,
    input  logic              mem_busy,
    output logic              req_valid,
    output logic              req_first,
    output logic [ROW_W-1:0]  req_row,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [ROW_W-1:0]  cur_row,
    output logic              overrun,
    output logic              in_frame
);
    import lps_pkg::*;

    logic [1:0] sync_rise;
    logic [1:0] sync_fall;
    lps_phase_e phase;
    logic       frame_start;
    logic       last_issue;

    lps_edge #(.W(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({hsync_in, vsync_in}),
        .rise  (sync_rise),
        .fall  (sync_fall)
    );

    lps_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .vs_level    (vsync_in),
        .vs_fall     (sync_fall[0]),
        .last_issue  (last_issue),
        .phase       (phase),
        .frame_start (frame_start)
    );

    lps_line_issuer #(.ROWS(ROWS), .ROW_W(ROW_W)) u_issuer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_lines    (phase == PH_LINES),
        .line_evt    (sync_rise[1]),
        .mem_busy    (mem_busy),
        .req_valid   (req_valid),
        .req_first   (req_first),
        .req_row     (req_row),
        .next_row    (cur_row),
        .overrun     (overrun),
        .last_issue  (last_issue)
    );

    assign req_addr = {req_row, {STRIDE_LOG2{1'b0}}};
    assign req_len  = LEN_W'(LINE_BYTES);
    assign in_frame = (phase == PH_LINES);

    logic unused_ok;
    assign unused_ok = ^{sync_rise[0], sync_fall[1]};

endmodule

// File: rtl/lps_checker.sv
// Property checker for the line prefetch sequencer, bound to the top.
module lps_checker #(
    parameter int ROWS  = 480,
    localparam int ROW_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_busy,
    input logic             req_valid,
    input logic [ROW_W-1:0] req_row,
    input logic [ROW_W-1:0] cur_row,
    input logic             overrun,
    input logic             in_frame
);

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_frame) |-> !req_valid);                          // R1
    AST_START_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> (cur_row == '0) && !overrun);          // R2
    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (int'(req_row) < ROWS));                     // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> (cur_row == '0));                      // R5
    AST_NOT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$past(mem_busy));                           // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> $rose(in_frame));                       // R9

endmodule

bind line_prefetch_seq lps_checker #(.ROWS(ROWS)) u_lps_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_busy  (mem_busy),
    .req_valid (req_valid),
    .req_row   (req_row),
    .cur_row   (cur_row),
    .overrun   (overrun),
    .in_frame  (in_frame)
);

// File: tb/line_prefetch_seq_bench.sv
module line_prefetch_seq_bench;

    localparam int ROWS = 6;
    localparam int SL2  = 10;
    localparam int RW   = $clog2(ROWS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync_in = 1'b0;
    logic hsync_in = 1'b0;
    logic mem_busy = 1'b0;
    logic req_valid, req_first, overrun, in_frame;
    logic [RW-1:0] req_row, cur_row;
    logic [RW+SL2-1:0] req_addr;
    logic [9:0] req_len;

    always #10 clk = ~clk;

    line_prefetch_seq #(.ROWS(ROWS), .LINE_PIXELS(640), .BPP(8), .STRIDE_LOG2(SL2))
    u_line_prefetch_seq (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hsync_in(hsync_in),
        .mem_busy(mem_busy), .req_valid(req_valid), .req_first(req_first),
        .req_row(req_row), .req_addr(req_addr), .req_len(req_len),
        .cur_row(cur_row), .overrun(overrun), .in_frame(in_frame)
    );

    typedef struct { int row; bit first; } exp_t;
    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each request as it appears.
    always @(negedge clk) begin
        if (rst_n && req_valid && !finished) begin
            if (q.size() == 0) begin
                check(0, "R1/R5/R7/R8 unexpected request", req_row, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(req_row == e.row, "R4 row", req_row, e.row);
                check(req_first == e.first, "R3 first flag", req_first, e.first);
                check(req_addr == e.row * 1024, "R6 addr", req_addr, e.row * 1024);
                check(req_len == 640, "R6 len", req_len, 640);
            end
        end
    end

    task automatic hs_pulse(input int hi);
        @(negedge clk) hsync_in = 1'b1;
        repeat (hi) @(negedge clk);
        hsync_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic line(input int row, input int hi);
        exp_t e;
        e.row = row; e.first = (row == 0);
        q.push_back(e);
        hs_pulse(hi);
    endtask

    task automatic arm();
        @(negedge clk) vsync_in = 1'b1;
        repeat (4) @(negedge clk);
        check(in_frame == 1'b0, "R1 not armed while vsync high", in_frame, 0);
        vsync_in = 1'b0;
        @(negedge clk);
        check(in_frame == 1'b1, "R1 armed after vsync fall", in_frame, 1);
        check(cur_row == 0, "R2 row zero at start", cur_row, 0);
        check(overrun == 1'b0, "R2 overrun cleared", overrun, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_valid == 0, "R1 reset req_valid", req_valid, 0);
        check(in_frame == 0, "R1 reset in_frame", in_frame, 0);
        check(cur_row == 0, "R2 reset cur_row", cur_row, 0);
        check(overrun == 0, "R9 reset overrun", overrun, 0);

        hs_pulse(2);
        check(cur_row == 0, "R1 hsync before frame ignored", cur_row, 0);

        arm();
        line(0, 5);
        check(cur_row == 1, "R4 held hsync one event", cur_row, 1);
        line(1, 1);
        line(2, 2);

        // Single event during busy: deferred.
        @(negedge clk) mem_busy = 1'b1;
        hs_pulse(1);
        check(overrun == 1, "R7 overrun on busy", overrun, 1);
        check(cur_row == 3, "R7 row held while busy", cur_row, 3);
        begin exp_t e; e.row = 3; e.first = 0; q.push_back(e); end
        mem_busy = 1'b0;
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R7 deferred request issued", q.size(), 0);
        check(cur_row == 4, "R7 row after deferral", cur_row, 4);

        // Two events during busy: second dropped.
        mem_busy = 1'b1;
        hs_pulse(1);
        hs_pulse(1);
        begin exp_t e; e.row = 4; e.first = 0; q.push_back(e); end
        mem_busy = 1'b0;
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R8 single request", q.size(), 0);
        check(cur_row == 5, "R8 row sequence", cur_row, 5);

        line(5, 1);
        check(in_frame == 0, "R5 frame ends after last row", in_frame, 0);
        check(cur_row == 0, "R5 row wraps", cur_row, 0);
        check(overrun == 1, "R9 overrun sticky past frame end", overrun, 1);
        hs_pulse(1);
        check(cur_row == 0, "R5 hsync after frame ignored", cur_row, 0);

        arm();
        for (int r = 0; r < ROWS; r++) line(r, 1 + r % 3);
        check(in_frame == 0, "R5 second frame ends", in_frame, 0);
        check(q.size() == 0, "R4 all requests seen", q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule